// File: doc/BRIEF.md
# SMBus Bus Timing Monitor

This block passively observes the clock and data wires of a two-wire system management bus. A fast local clock samples them. Each wire passes through a two-stage synchronizer. The block then reports framing events and bus state to the surrounding logic. It flags a START condition (data falling while the clock is high) and a STOP condition (data rising while the clock is high). It keeps a busy flag between the two.

The block also enforces three timing rules of the bus. The first is a clock-low timeout: a clock held low for too long ends the transaction and treats the bus as reset. The second is a minimum data hold window after every clock falling edge. The third is an idle rule based on the slowest legal clock rate: a clock that stays high for longer than one period of that rate while the bus is busy frees the bus without a STOP. All thresholds are given in microseconds or nanoseconds and converted to cycles through a cycles-per-microsecond parameter. The monitor never drives either wire and does not decode bytes.

Top module: `smb_timing_monitor`

## Requirements
- R1: After a synchronous active-high reset, `busy_o` is 0, `idle_o` is 1, and no pulse output is high.
- R2: A data falling edge while the clock is high gives exactly one single-cycle `start_o` pulse, and `busy_o` becomes 1.
- R3: A data rising edge while the clock is high gives exactly one single-cycle `stop_o` pulse, and `busy_o` becomes 0.
- R4: A START while already busy gives a `start_o` pulse, and `busy_o` stays 1.
- R5: Data transitions while the clock is low give neither a `start_o` nor a `stop_o` pulse, and leave `busy_o` unchanged.
- R6: A clock held continuously low for TIMEOUT_US microseconds gives exactly one single-cycle `tmo_o` pulse and clears `busy_o`. No further pulse follows while the clock stays low.
- R7: Every clock edge restarts the low-time measurement. Several low periods, each shorter than the limit, never time out even when their sum exceeds it.
- R8: A data change within HOLD_NS nanoseconds after a clock falling edge, measured from the cycle of the fall and while the clock is still low, gives one `hold_err_o` pulse. A data change in the same cycle as the fall counts as inside the window.
- R9: A data change after the hold window has elapsed gives no `hold_err_o` pulse.
- R10: While busy, a clock that stays high for IDLE_US microseconds with no START or STOP clears `busy_o` and sets `idle_o`, with no `stop_o` pulse.
- R11: While busy, a clock high time shorter than IDLE_US microseconds leaves `busy_o` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Raw bus clock wire level |
| sda_i | input | 1 | Raw bus data wire level |
| start_o | output | 1 | One-cycle pulse on a START condition |
| stop_o | output | 1 | One-cycle pulse on a STOP condition |
| busy_o | output | 1 | Bus held by a transaction |
| tmo_o | output | 1 | One-cycle pulse on a clock-low timeout |
| hold_err_o | output | 1 | One-cycle pulse on a data hold violation |
| idle_o | output | 1 | Bus free |

## Verification
The bench goes after a repeated START. A design that treated this as a toggle would drop `busy_o` in the middle of a transaction. It sends data toggles while the clock is low, which a detector that ignored the clock level would report as START or STOP. It feeds a chain of low periods, each under the limit but longer in total. A timer that was not restarted on clock edges would fire a false timeout. A timer that was not saturating would fire repeatedly during one long low period. It probes the hold window from both sides. Finally, it parks the clock high while busy, for a time below and a time above the idle limit, to catch a monitor that waits for a STOP forever or releases the bus too early.

// File: rtl/smb_mon_pkg.sv
package smb_mon_pkg;

    // Events seen on the synchronized wires in the current cycle
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic sda_chg;
        logic start;
        logic stop;
    } smb_evt_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = raw_i;
        st_d.stable = st_q.meta;
    end

    // Released open-drain wires idle high, so reset to ones
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{meta: '1, stable: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect
    import smb_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output smb_evt_t evt_o
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } prev_st_t;

    prev_st_t st_d, st_q;
    smb_evt_t evt;

    always_comb begin
        st_d       = st_q;
        st_d.scl_p = scl_s;
        st_d.sda_p = sda_s;

        evt          = '0;
        evt.scl_rise = scl_s & ~st_q.scl_p;
        evt.scl_fall = ~scl_s & st_q.scl_p;
        evt.sda_chg  = sda_s ^ st_q.sda_p;
        // Clock must be high in both samples, so a simultaneous clock edge is not framing
        evt.start    = scl_s & st_q.scl_p & st_q.sda_p & ~sda_s;
        evt.stop     = scl_s & st_q.scl_p & ~st_q.sda_p & sda_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = evt;
endmodule

// File: rtl/smb_timing_monitor.sv
module smb_timing_monitor
    import smb_mon_pkg::*;
#(
    parameter int unsigned CLKS_PER_US = 100,
    parameter int unsigned TIMEOUT_US  = 35000,
    parameter int unsigned HOLD_NS     = 300,
    parameter int unsigned IDLE_US     = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic busy_o,
    output logic tmo_o,
    output logic hold_err_o,
    output logic idle_o
);
    localparam int unsigned LOW_LIM  = at_least_one(TIMEOUT_US * CLKS_PER_US);
    localparam int unsigned HIGH_LIM = at_least_one(IDLE_US * CLKS_PER_US);
    localparam int unsigned HOLD_CYC = at_least_one(ceil_div(HOLD_NS * CLKS_PER_US, 1000));
    localparam int unsigned LW       = $clog2(LOW_LIM + 1);
    localparam int unsigned HW       = $clog2(HIGH_LIM + 1);
    localparam int unsigned DW       = $clog2(HOLD_CYC + 1);

    localparam logic [LW-1:0] LOW_MAX   = LW'(LOW_LIM);
    localparam logic [LW-1:0] LOW_LAST  = LW'(LOW_LIM - 1);
    localparam logic [HW-1:0] HIGH_MAX  = HW'(HIGH_LIM);
    localparam logic [HW-1:0] HIGH_LAST = HW'(HIGH_LIM - 1);
    localparam logic [DW-1:0] HOLD_LOAD = DW'(HOLD_CYC - 1);

    typedef struct packed {
        logic          busy;
        logic [LW-1:0] low_cnt;
        logic [HW-1:0] high_cnt;
        logic [DW-1:0] hold_cnt;
        logic          start;
        logic          stop;
        logic          tmo;
        logic          hold_err;
    } mon_st_t;

    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;
    smb_evt_t   evt;
    mon_st_t    st_d, st_q;

    smb_sync #(.WIDTH(2)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  ({scl_i, sda_i}),
        .sync_o (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    smb_cond_detect i_detect (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .evt_o (evt)
    );

    logic scl_edge;
    logic tmo_ev;
    logic idle_ev;
    logic in_hold;

    always_comb begin
        st_d     = st_q;
        scl_edge = evt.scl_rise | evt.scl_fall;

        // Clock-low timer: restarted by every edge, saturating at the limit
        tmo_ev = ~scl_s & ~scl_edge & (st_q.low_cnt == LOW_LAST);
        if (scl_s || scl_edge) begin
            st_d.low_cnt = '0;
        end else if (st_q.low_cnt != LOW_MAX) begin
            st_d.low_cnt = st_q.low_cnt + 1'b1;
        end

        // Clock-high timer: only while busy, restarted by edges and framing
        idle_ev = st_q.busy & scl_s & ~scl_edge & ~evt.start & ~evt.stop
                  & (st_q.high_cnt == HIGH_LAST);
        if (!st_q.busy || !scl_s || scl_edge || evt.start || evt.stop) begin
            st_d.high_cnt = '0;
        end else if (st_q.high_cnt != HIGH_MAX) begin
            st_d.high_cnt = st_q.high_cnt + 1'b1;
        end

        // Hold window: the fall cycle plus HOLD_CYC-1 following cycles
        in_hold = evt.scl_fall | (st_q.hold_cnt != '0);
        if (evt.scl_fall) begin
            st_d.hold_cnt = HOLD_LOAD;
        end else if (st_q.hold_cnt != '0) begin
            st_d.hold_cnt = st_q.hold_cnt - 1'b1;
        end

        st_d.hold_err = in_hold & evt.sda_chg & ~scl_s;
        st_d.start    = evt.start;
        st_d.stop     = evt.stop;
        st_d.tmo      = tmo_ev;

        if (evt.start) begin
            st_d.busy = 1'b1;
        end else if (evt.stop || tmo_ev || idle_ev) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o    = st_q.start;
    assign stop_o     = st_q.stop;
    assign busy_o     = st_q.busy;
    assign tmo_o      = st_q.tmo;
    assign hold_err_o = st_q.hold_err;
    assign idle_o     = ~st_q.busy;
endmodule

// File: rtl/smb_timing_monitor_chk.sv
module smb_timing_monitor_chk (
    input logic clk,
    input logic rst,
    input logic start_o,
    input logic stop_o,
    input logic busy_o,
    input logic tmo_o,
    input logic hold_err_o
);
    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> busy_o);

    // R2
    busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> start_o);

    // R3
    stop_frees_bus_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> !busy_o);

    // R6
    tmo_frees_bus_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_o |-> !busy_o);

    // R6
    tmo_single_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_o |=> !tmo_o);

    // R8
    hold_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        hold_err_o |-> !(start_o || stop_o));

    // R3
    framing_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_o && stop_o));
endmodule

bind smb_timing_monitor smb_timing_monitor_chk i_chk (.*);

// File: tb/test_smb_timing_monitor.sv
`timescale 1ns/100ps
module test_smb_timing_monitor;
    localparam int unsigned CPU = 10;  // 10 cycles per microsecond in the bench
    localparam int unsigned TMO = 50;  // 500 cycles
    localparam int unsigned HLD = 300; // 3 cycles
    localparam int unsigned IDL = 10;  // 100 cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic start_o, stop_o, busy_o, tmo_o, hold_err_o, idle_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_start = 0, n_stop = 0, n_tmo = 0, n_hold = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    smb_timing_monitor #(
        .CLKS_PER_US(CPU), .TIMEOUT_US(TMO), .HOLD_NS(HLD), .IDLE_US(IDL)
    ) i_smb_timing_monitor (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .start_o(start_o), .stop_o(stop_o), .busy_o(busy_o),
        .tmo_o(tmo_o), .hold_err_o(hold_err_o), .idle_o(idle_o)
    );

    // Pulse counters sampled half a period away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (start_o)    n_start++;
            if (stop_o)     n_stop++;
            if (tmo_o)      n_tmo++;
            if (hold_err_o) n_hold++;
        end
    end

    typedef struct packed {
        logic       scl;
        logic       sda;
        logic [1:0] d_start;
        logic [1:0] d_stop;
        logic       busy;
    } vec_t;

    // Each step is held 8 cycles, well under the idle and timeout limits
    localparam vec_t VECS [12] = '{
        '{1'b1, 1'b0, 2'd1, 2'd0, 1'b1},  // START
        '{1'b0, 1'b0, 2'd0, 2'd0, 1'b1},  // clock low
        '{1'b0, 1'b1, 2'd0, 2'd0, 1'b1},  // data toggles with clock low
        '{1'b1, 1'b1, 2'd0, 2'd0, 1'b1},  // clock high
        '{1'b1, 1'b0, 2'd1, 2'd0, 1'b1},  // repeated START
        '{1'b0, 1'b0, 2'd0, 2'd0, 1'b1},
        '{1'b0, 1'b1, 2'd0, 2'd0, 1'b1},  // data toggles with clock low
        '{1'b0, 1'b0, 2'd0, 2'd0, 1'b1},
        '{1'b1, 1'b0, 2'd0, 2'd0, 1'b1},
        '{1'b1, 1'b1, 2'd0, 2'd1, 1'b0},  // STOP
        '{1'b1, 1'b0, 2'd1, 2'd0, 1'b1},  // START
        '{1'b1, 1'b1, 2'd0, 2'd1, 1'b0}   // STOP
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic drive(input logic c, input logic d, input int n);
        scl = c;
        sda = d;
        wait_cyc(n);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual run unfinished, expected finished");
            summary();
        end
    end

    initial begin
        int s0, p0, t0, h0;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);

        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 idle", idle_o, 1);
        chk("R1 pulses", {start_o, stop_o, tmo_o, hold_err_o}, 0);

        // Table walk: R2 START, R3 STOP, R4 repeated START, R5 low-clock data
        h0 = n_hold;
        for (int i = 0; i < 12; i++) begin
            s0 = n_start;
            p0 = n_stop;
            drive(VECS[i].scl, VECS[i].sda, 8);
            chk($sformatf("R2/R4 start step %0d", i), n_start - s0, int'(VECS[i].d_start));
            chk($sformatf("R3/R5 stop step %0d", i), n_stop - p0, int'(VECS[i].d_stop));
            chk($sformatf("R2/R3/R5 busy step %0d", i), busy_o, int'(VECS[i].busy));
        end
        chk("R9 no hold error in slow table", n_hold - h0, 0);

        // R6 timeout while busy, single pulse, saturating
        drive(1, 0, 8);
        drive(0, 0, 700);
        chk("R6 one timeout", n_tmo, 1);
        chk("R6 busy cleared", busy_o, 0);
        wait_cyc(700);
        chk("R6 no repeat", n_tmo, 1);
        drive(1, 0, 8);
        drive(1, 1, 8);

        // R7 short low periods summing past the limit
        t0 = n_tmo;
        drive(1, 0, 8);
        for (int k = 0; k < 3; k++) begin
            drive(0, 0, 300);
            drive(1, 0, 20);
        end
        chk("R7 no timeout", n_tmo - t0, 0);
        chk("R7 still busy", busy_o, 1);

        // R8 data change one cycle after clock fall
        h0 = n_hold;
        scl = 1'b0;
        wait_cyc(1);
        sda = 1'b1;
        wait_cyc(8);
        chk("R8 hold error", n_hold - h0, 1);

        // R9 data change after the window
        drive(1, 1, 8);
        h0 = n_hold;
        scl = 1'b0;
        wait_cyc(10);
        sda = 1'b0;
        wait_cyc(8);
        chk("R9 no hold error", n_hold - h0, 0);
        drive(1, 0, 8);
        drive(1, 1, 8);

        // R11 short high time keeps busy
        drive(1, 0, 50);
        chk("R11 busy after short high", busy_o, 1);

        // R10 long high time releases the bus without STOP
        p0 = n_stop;
        wait_cyc(150);
        chk("R10 busy cleared", busy_o, 0);
        chk("R10 idle set", idle_o, 1);
        chk("R10 no stop pulse", n_stop - p0, 0);
        drive(1, 1, 8);

        done = 1'b1;
        summary();
    end
endmodule